// File: doc/BRIEF.md
# Paired-Line Instruction Cache

This block is a small, read-only instruction cache with two ways per set and 64-byte lines. A fetch unit presents a byte address. On a hit the whole line comes back one cycle later. On a miss the cache stalls new fetches and fetches from a lower-level memory port. It fetches the missing line and then its companion line, which is the other half of the naturally aligned 128-byte block. Loading the companion is a prefetch of the code that most likely follows.

Each stored line carries one parity bit. The lower level supplies this bit with the fill data, and the cache checks it on every hit. When a line fails the check, the cache does not return it. It invalidates the line, reports a one-cycle error pulse and fetches the line again. Only one miss is handled at a time. Each set has a single recency bit that selects the replacement victim.

Top module: `paired_icache`

## Requirements
- R1: After reset no line is valid, and `req_stall`, `rsp_valid`, `par_err` and `mem_req_valid` are all low.
- R2: A fetch is accepted in a cycle with `req_valid` high and `req_stall` low. The line address is `req_addr[ADDR_W-1:6]`. Its low `log2(SETS)` bits select the set and the remaining bits form the tag. On a hit, `rsp_valid` is high for exactly the following cycle and `rsp_data` holds the stored line.
- R3: On a miss, from the cycle after acceptance `req_stall` and `mem_req_valid` are high and `mem_req_line` equals the missing line address. Both hold until a cycle with `mem_rsp_valid` high.
- R4: In the cycle after the fill of the missing line arrives, `rsp_valid` is high and `rsp_data` equals the returned data. The companion line is never presented on `rsp_valid`.
- R5: After the missing line, the cache requests the companion line (line address with bit 0 inverted). If the companion is already valid at the time of the miss, it issues no second request and `req_stall` drops after the first fill.
- R6: `req_stall` stays high until the last fill of the pair is installed. A `req_valid` raised while stalled produces no response and does not change the memory request.
- R7: A fill goes into an invalid way of its set (way 0 before way 1). If both ways are valid, it goes into the way named by the set's recency bit. Each hit and each fill sets that bit to the other way.
- R8: A line is never held in both ways of a set. A line refetched after a parity error reuses the invalidated way.
- R9: The fill port supplies an even-parity bit (the XOR of all 512 data bits), which is stored with the line. A hit on a line whose stored bit differs from the XOR of its stored data raises `par_err` for one cycle, gives no response, invalidates the line and proceeds as a miss.
- R10: `mem_rsp_valid` is ignored while no memory request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request |
| req_addr | input | ADDR_W | Fetch byte address |
| req_stall | output | 1 | Cache busy; requests are not accepted |
| rsp_valid | output | 1 | Response line valid |
| rsp_data | output | 512 | Returned 64-byte line |
| par_err | output | 1 | One-cycle parity error pulse |
| mem_req_valid | output | 1 | Line fill request outstanding |
| mem_req_line | output | ADDR_W-6 | Line address requested |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_data | input | 512 | Fill line data |
| mem_rsp_par | input | 1 | Even parity of the fill data |

## Verification
The hardest state to reach is a miss whose companion is already resident. Fills always come in pairs, so this state normally requires one half of a block to be evicted while the other half survives. The stimulus reaches it through the parity path. The bench memory model returns a wrong parity bit for a chosen line. The next hit on that line must pulse the error flag, invalidate only that line and refetch it alone. A random stream over four tags per set also mixes in evictions, stalled requests and stray fill responses.

// File: rtl/icf_pkg.sv
package icf_pkg;
    localparam int ICF_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_PAIR = 2'd2
    } icf_state_e;
endpackage

// File: rtl/icf_parity.sv
module icf_parity #(
    parameter int W = 512
) (
    input  logic [W-1:0] d,
    output logic         p
);
    assign p = ^d;
endmodule

// File: rtl/icf_tag_probe.sv
module icf_tag_probe #(
    parameter int TAG_W = 7
) (
    input  logic [icf_pkg::ICF_WAYS-1:0]            vld,
    input  logic [icf_pkg::ICF_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]                        key,
    output logic [icf_pkg::ICF_WAYS-1:0]            hit
);
    for (genvar w = 0; w < icf_pkg::ICF_WAYS; w++) begin : g_way
        assign hit[w] = vld[w] && (tags[w] == key);
    end
endmodule

// File: rtl/icf_victim.sv
module icf_victim (
    input  logic [1:0] vld,
    input  logic       lru,
    output logic       way
);
    always_comb begin
        if (!vld[0])      way = 1'b0;
        else if (!vld[1]) way = 1'b1;
        else              way = lru;
    end
endmodule

// File: rtl/paired_icache.sv
module paired_icache
    import icf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 8,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_stall,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic              par_err,
    output logic              mem_req_valid,
    output logic [LA_W-1:0]   mem_req_line,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_par
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LA_W - IDX_W;

    typedef struct packed {
        icf_state_e                                   st;
        logic [LA_W-1:0]                              line;
        logic                                         need_pair;
        logic                                         rsp_v;
        logic [LINE_W-1:0]                            rsp_d;
        logic                                         perr;
        logic [SETS-1:0][ICF_WAYS-1:0]                vld;
        logic [SETS-1:0][ICF_WAYS-1:0][TAG_W-1:0]     tag;
        logic [SETS-1:0][ICF_WAYS-1:0]                par;
        logic [SETS-1:0][ICF_WAYS-1:0][LINE_W-1:0]    dat;
        logic [SETS-1:0]                              lru;
    } icf_regs_t;

    icf_regs_t r_d, r_q;

    // request decode
    logic [LA_W-1:0]  req_line;
    logic [IDX_W-1:0] req_set;
    logic [IDX_W-1:0] comp_set;
    logic [TAG_W-1:0] req_tag;
    logic             unused_ofs;

    assign req_line   = req_addr[ADDR_W-1:OFS_W];
    assign req_set    = req_line[IDX_W-1:0];
    assign comp_set   = req_set ^ IDX_W'(1);
    assign req_tag    = req_line[LA_W-1:IDX_W];
    assign unused_ofs = ^req_addr[OFS_W-1:0];

    // lookup of the requested line and its companion
    logic [ICF_WAYS-1:0] own_match, comp_match, calc_par, own_bad, own_good;
    logic                hit_way;

    icf_tag_probe #(.TAG_W(TAG_W)) u_probe_own (
        .vld (r_q.vld[req_set]),
        .tags(r_q.tag[req_set]),
        .key (req_tag),
        .hit (own_match)
    );

    icf_tag_probe #(.TAG_W(TAG_W)) u_probe_comp (
        .vld (r_q.vld[comp_set]),
        .tags(r_q.tag[comp_set]),
        .key (req_tag),
        .hit (comp_match)
    );

    for (genvar w = 0; w < ICF_WAYS; w++) begin : g_chk
        icf_parity #(.W(LINE_W)) u_par (
            .d(r_q.dat[req_set][w]),
            .p(calc_par[w])
        );
        assign own_bad[w]  = own_match[w] && (calc_par[w] != r_q.par[req_set][w]);
        assign own_good[w] = own_match[w] && !own_bad[w];
    end

    assign hit_way = own_good[1];

    // fill target
    logic [LA_W-1:0]  fill_line;
    logic [IDX_W-1:0] fill_set;
    logic             vic_way;

    assign fill_line = (r_q.st == ST_PAIR) ? (r_q.line ^ LA_W'(1)) : r_q.line;
    assign fill_set  = fill_line[IDX_W-1:0];

    icf_victim u_victim (
        .vld(r_q.vld[fill_set]),
        .lru(r_q.lru[fill_set]),
        .way(vic_way)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.perr  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (|own_good) begin
                        r_d.rsp_v          = 1'b1;
                        r_d.rsp_d          = r_q.dat[req_set][hit_way];
                        r_d.lru[req_set]   = ~hit_way;
                    end else begin
                        r_d.vld[req_set]   = r_q.vld[req_set] & ~own_bad;
                        r_d.perr           = |own_bad;
                        r_d.line           = req_line;
                        r_d.need_pair      = ~|comp_match;
                        r_d.st             = ST_OWN;
                    end
                end
            end
            ST_OWN, ST_PAIR: begin
                if (mem_rsp_valid) begin
                    r_d.vld[fill_set][vic_way] = 1'b1;
                    r_d.tag[fill_set][vic_way] = r_q.line[LA_W-1:IDX_W];
                    r_d.dat[fill_set][vic_way] = mem_rsp_data;
                    r_d.par[fill_set][vic_way] = mem_rsp_par;
                    r_d.lru[fill_set]          = ~vic_way;
                    if (r_q.st == ST_OWN) begin
                        r_d.rsp_v = 1'b1;
                        r_d.rsp_d = mem_rsp_data;
                        r_d.st    = r_q.need_pair ? ST_PAIR : ST_IDLE;
                    end else begin
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_stall     = (r_q.st != ST_IDLE);
    assign mem_req_valid = (r_q.st != ST_IDLE);
    assign mem_req_line  = fill_line;
    assign rsp_valid     = r_q.rsp_v;
    assign rsp_data      = r_q.rsp_d;
    assign par_err       = r_q.perr;

    // R8
    way_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_match));

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_line)));

    // R5
    pair_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid) |=>
            (!mem_req_valid || (mem_req_line == ($past(mem_req_line) ^ LA_W'(1)))));

    // R4
    own_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OWN && mem_rsp_valid) |=> (rsp_valid && rsp_data == $past(mem_rsp_data)));

    // R9
    perr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (req_stall && !rsp_valid));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stall && !mem_rsp_valid) |=> !rsp_valid);

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_valid && !req_valid) |=> (!rsp_valid && !mem_req_valid));
endmodule

// File: tb/sim_paired_icache.sv
`timescale 1ns/1ps
module sim_paired_icache;
    localparam int AW = 16;
    localparam int LW = 512;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_stall, rsp_valid, par_err, mem_req_valid;
    logic [LW-1:0] rsp_data;
    logic [AW-7:0] mem_req_line;
    logic          mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_data = '0;
    logic          mem_rsp_par = 1'b0;

    always #4 clk = ~clk;

    paired_icache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_stall(req_stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .par_err(par_err), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_par(mem_rsp_par)
    );

    int checks = 0;
    int errors = 0;

    // reference model
    bit          mv[NS][2];
    int unsigned mt[NS][2];
    bit          mb[NS][2];
    bit          ml[NS];
    bit          arm = 0;
    int unsigned corrupt_la = 0;

    function automatic logic [LW-1:0] line_data(int unsigned la);
        logic [LW-1:0] d;
        for (int i = 0; i < 16; i++)
            d[i*32 +: 32] = (la * 32'h9E3779B1 + i * 32'h01000193) ^ 32'h5A5A0000;
        return d;
    endfunction

    task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_install(int unsigned s, int unsigned t, bit bad);
        int w;
        if (!mv[s][0])      w = 0;
        else if (!mv[s][1]) w = 1;
        else                w = int'(ml[s]);
        mv[s][w] = 1; mt[s][w] = t; mb[s][w] = bad;
        ml[s] = (w == 0);
    endtask

    task automatic serve(int unsigned la, int lat, bit poke, output bit bad);
        logic [LW-1:0] d;
        for (int k = 0; k < lat; k++) begin
            check(mem_req_valid && mem_req_line == la[AW-7:0], "R3", "request held",
                  64'(mem_req_line), 64'(la));
            if (poke && k == 0) begin
                req_valid = 1'b1;
                req_addr  = AW'($urandom);
            end
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            if (poke && k == 0)
                check(!rsp_valid, "R6", "request while stalled", 64'(rsp_valid), 64'd0);
        end
        check(mem_req_valid && mem_req_line == la[AW-7:0], "R3", "request line",
              64'(mem_req_line), 64'(la));
        d   = line_data(la);
        bad = arm && (la == corrupt_la);
        if (bad) arm = 0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = d;
        mem_rsp_par   = (^d) ^ bad;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    task automatic do_fetch(int unsigned addr, int lat, bit poke, string rq);
        int unsigned la, s, t, cs;
        int hw;
        bit perr, comp, bad;
        la = (addr >> 6) & 32'h3FF; s = la % NS; t = la / NS; cs = s ^ 1;
        hw = -1;
        for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
        req_valid = 1'b1; req_addr = addr[AW-1:0];
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (hw >= 0 && !mb[s][hw]) begin
            check(rsp_valid, rq, "hit response", 64'(rsp_valid), 64'd1);
            check(rsp_data == line_data(la), "R2", "hit data", rsp_data[63:0], line_data(la) >> 0);
            check(!req_stall && !par_err, "R2", "no stall on hit", 64'(req_stall), 64'd0);
            ml[s] = (hw == 0);
            return;
        end
        perr = (hw >= 0);
        if (perr) mv[s][hw] = 0;
        comp = 0;
        for (int w = 0; w < 2; w++) if (mv[cs][w] && mt[cs][w] == t) comp = 1;
        check(par_err == perr, "R9", "parity flag", 64'(par_err), 64'(perr));
        check(!rsp_valid, rq, "no response on miss", 64'(rsp_valid), 64'd0);
        check(req_stall, "R3", "stall on miss", 64'(req_stall), 64'd1);
        serve(la, lat, poke, bad);
        model_install(s, t, bad);
        check(rsp_valid, "R4", "own line response", 64'(rsp_valid), 64'd1);
        check(rsp_data == line_data(la), "R4", "own line data", rsp_data[63:0], line_data(la) >> 0);
        if (!comp) begin
            check(mem_req_valid && mem_req_line == (la ^ 1), "R5", "companion request",
                  64'(mem_req_line), 64'(la ^ 1));
            check(req_stall, "R6", "stall during companion", 64'(req_stall), 64'd1);
            serve(la ^ 1, int'($urandom % 3), 0, bad);
            model_install(cs, t, bad);
            check(!rsp_valid, "R4", "companion not returned", 64'(rsp_valid), 64'd0);
        end else begin
            check(!mem_req_valid, "R5", "no companion request", 64'(mem_req_valid), 64'd0);
        end
        check(!req_stall, "R6", "stall released", 64'(req_stall), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1CE5));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!req_stall && !rsp_valid && !par_err && !mem_req_valid, "R1", "reset outputs",
              {60'd0, req_stall, rsp_valid, par_err, mem_req_valid}, 64'd0);

        do_fetch(32'h0000, 2, 0, "R2");
        do_fetch(32'h0044, 0, 0, "R2");
        do_fetch(32'h00A0, 1, 1, "R6");
        do_fetch(32'h00C3, 0, 0, "R2");

        // R7: three tags competing for sets 0 and 1
        do_fetch(32'h0200, 1, 0, "R7");
        do_fetch(32'h0000, 0, 0, "R7");
        do_fetch(32'h0400, 3, 0, "R7");
        do_fetch(32'h0240, 0, 0, "R7");
        do_fetch(32'h0200, 0, 0, "R7");

        // R9 and R8: corrupt one half of a pair, then refetch it alone
        arm = 1; corrupt_la = 40;
        do_fetch(40 * 64, 1, 0, "R9");
        do_fetch(41 * 64, 0, 0, "R8");
        do_fetch(40 * 64 + 5, 2, 0, "R9");
        do_fetch(40 * 64 + 9, 0, 0, "R8");

        // R10: stray fill response while idle
        mem_rsp_valid = 1'b1; mem_rsp_data = line_data(60); mem_rsp_par = ^line_data(60);
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(!rsp_valid && !mem_req_valid, "R10", "stray fill ignored",
              {62'd0, rsp_valid, mem_req_valid}, 64'd0);
        do_fetch(60 * 64, 0, 0, "R10");

        for (int n = 0; n < 400; n++) begin
            int unsigned la;
            la = ($urandom % 4) * NS + ($urandom % NS);
            if ($urandom % 12 == 0) begin arm = 1; corrupt_la = la; end
            do_fetch(la * 64 + ($urandom % 64), int'($urandom % 4), ($urandom % 5) == 0, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule